// File: doc/BRIEF.md
# 6x6 Carry-Save Multiplier Slice

This block multiplies two unsigned 6-bit operands with no clock. It stops short of a final carry-propagate adder. The product comes out in redundant form as two vectors. The first is an 11-bit vector on columns 0 to 10. The second is a 6-bit vector that sits on columns 5 to 10. Its five lower columns are implicitly zero and have no port. The sum of the two vectors is the exact 12-bit product. Column 11 appears only when a later stage adds the two vectors.

Partial products are plain AND terms, with no recoding. The top row of the partial-product array belongs to the multiplier's most significant bit. That row goes straight to the upper vector as single pass-through bits. The five lower rows are compressed by one row of column counters. Each counter takes the bits of its own column plus the in-row carry count from the column below. It emits one sum bit and hands the rest of its count upward. A counter of height two acts as a (2,2) cell, one of height three as a (3,2) cell, and one of height one passes its bit through. The block is meant to be tiled under a larger multiplier. That multiplier merges several such slices before a single fast adder.

Top module: `csmul6x6`

## Requirements
- R1: For every operand pair, p_o + (q_o << 5), evaluated at 12 bits, equals a_i * b_i.
- R2: When b_i[5] is 0, q_o is 0.
- R3: When b_i[5] is 1, q_o equals a_i bit for bit (q_o[k] carries weight 2^(k+5)).
- R4: p_o equals a_i * b_i[4:0], the product of the multiplicand with the five low multiplier bits.
- R5: When either operand is 0, both p_o and q_o are 0. This is also the state with both operands held at 0 after power-up.
- R6: p_o never exceeds 1953 (63 * 31), and the counter row never carries past column 10. For a_i = b_i = 63 this gives p_o = 1953 and q_o = 63, and bit 11 of the product comes only from their sum.
- R7: p_o[0] equals a_i[0] & b_i[0], because column 0 holds a single bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 6 | Multiplicand, unsigned |
| b_i | input | 6 | Multiplier, unsigned |
| p_o | output | 11 | Lower redundant vector, columns 10..0 |
| q_o | output | 6 | Upper redundant vector, columns 10..5 |

## Verification
Every result is due in the same cycle as its operands, with zero register stages between a_i/b_i and p_o/q_o. The driver applies a new operand pair just after a rising edge and queues the expected vectors. The monitor pops the queue and compares at the following falling edge, half a period later, when the logic has settled and before the next pair arrives. The run covers directed corners first, including both zero operands, all-ones operands, and the case where only b_i[5] is set. It then sweeps all 4096 operand pairs.

// File: rtl/csmul_pkg.sv
`timescale 1ns/1ps
package csmul_pkg;
  localparam int unsigned MUL_A_W = 6;
  localparam int unsigned MUL_B_W = 6;

  // width of a column count: a column total is bounded by twice the tallest column
  function automatic int unsigned cnt_width(input int unsigned h);
    return $clog2(2 * h + 1);
  endfunction
endpackage

// File: rtl/pp_array.sv
`timescale 1ns/1ps
module pp_array #(
  parameter int unsigned A_W = 6,
  parameter int unsigned B_W = 6
) (
  input  logic [A_W-1:0]          a_i,
  input  logic [B_W-1:0]          b_i,
  output logic [B_W-1:0][A_W-1:0] pp_o
);
  for (genvar j = 0; j < B_W; j++) begin : g_row
    assign pp_o[j] = a_i & {A_W{b_i[j]}};
  end
endmodule

// File: rtl/col_counter.sv
`timescale 1ns/1ps
module col_counter #(
  parameter int unsigned N_IN  = 6,
  parameter int unsigned CNT_W = 4
) (
  input  logic [N_IN-1:0]  bits_i,
  input  logic [CNT_W-1:0] cin_i,
  output logic             sum_o,
  output logic [CNT_W-1:0] cout_o
);
  logic [CNT_W-1:0] total;

  always_comb begin
    total = cin_i;
    for (int i = 0; i < N_IN; i++) total = total + CNT_W'(bits_i[i]);
  end

  assign sum_o  = total[0];
  assign cout_o = total >> 1;
endmodule

// File: rtl/counter_row.sv
`timescale 1ns/1ps
module counter_row #(
  parameter int unsigned A_W  = 6,
  parameter int unsigned ROWS = 5,
  parameter int unsigned P_W  = 11
) (
  input  logic [ROWS-1:0][A_W-1:0] pp_i,
  output logic [P_W-1:0]           sum_o,
  output logic                     spill_o
);
  localparam int unsigned H_MAX = (A_W < ROWS) ? A_W : ROWS;
  localparam int unsigned CNT_W = csmul_pkg::cnt_width(H_MAX);

  logic [P_W-1:0][A_W-1:0] col_bits;
  logic [P_W:0][CNT_W-1:0] carry;

  // gather column k: bit i of the column is pp[k-i][i]
  for (genvar k = 0; k < P_W; k++) begin : g_col
    for (genvar i = 0; i < A_W; i++) begin : g_bit
      localparam int J = k - i;
      if (J >= 0 && J < ROWS) begin : g_pp
        assign col_bits[k][i] = pp_i[J][i];
      end else begin : g_zero
        assign col_bits[k][i] = 1'b0;
      end
    end
  end

  assign carry[0] = '0;

  for (genvar k = 0; k < P_W; k++) begin : g_cnt
    col_counter #(
      .N_IN (A_W),
      .CNT_W(CNT_W)
    ) u_col (
      .bits_i(col_bits[k]),
      .cin_i (carry[k]),
      .sum_o (sum_o[k]),
      .cout_o(carry[k+1])
    );
  end

  assign spill_o = |carry[P_W];
endmodule

// File: rtl/csmul6x6.sv
`timescale 1ns/1ps
module csmul6x6 #(
  parameter int unsigned A_W = csmul_pkg::MUL_A_W,
  parameter int unsigned B_W = csmul_pkg::MUL_B_W,
  localparam int unsigned P_W = A_W + B_W - 1
) (
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic [P_W-1:0] p_o,
  output logic [A_W-1:0] q_o
);
  logic [B_W-1:0][A_W-1:0] pp;
  logic                    row_spill;

  pp_array #(
    .A_W(A_W),
    .B_W(B_W)
  ) u_pp (
    .a_i (a_i),
    .b_i (b_i),
    .pp_o(pp)
  );

  // lower rows reduced by one row of column counters
  counter_row #(
    .A_W (A_W),
    .ROWS(B_W - 1),
    .P_W (P_W)
  ) u_row (
    .pp_i   (pp[B_W-2:0]),
    .sum_o  (p_o),
    .spill_o(row_spill)
  );

  // top row passes straight to the upper vector
  assign q_o = pp[B_W-1];
endmodule

// File: rtl/csmul6x6_chk.sv
`timescale 1ns/1ps
module csmul6x6_chk #(
  parameter int unsigned A_W = 6,
  parameter int unsigned B_W = 6,
  localparam int unsigned P_W = A_W + B_W - 1,
  localparam int unsigned F_W = A_W + B_W
) (
  input logic [A_W-1:0] a_i,
  input logic [B_W-1:0] b_i,
  input logic [P_W-1:0] p_o,
  input logic [A_W-1:0] q_o,
  input logic           row_spill
);
  logic [F_W-1:0] full_prod;
  logic [F_W-1:0] cs_sum;
  logic [F_W-1:0] low_prod;
  logic           known;

  assign full_prod = F_W'(a_i) * F_W'(b_i);
  assign cs_sum    = F_W'(p_o) + (F_W'(q_o) << (B_W - 1));
  assign low_prod  = F_W'(a_i) * F_W'(b_i[B_W-2:0]);
  assign known     = !$isunknown({a_i, b_i, p_o, q_o, row_spill});

  always_comb begin
    if (known) begin
      AST_CS_EXACT: assert (cs_sum == full_prod) else $error("cs sum mismatch"); // R1
      AST_Q_GATED: assert (b_i[B_W-1] || q_o == '0) else $error("q not gated"); // R2
      AST_Q_COPY: assert (!b_i[B_W-1] || q_o == a_i) else $error("q not copy"); // R3
      AST_P_LOW_ROWS: assert (F_W'(p_o) == low_prod) else $error("p mismatch"); // R4
      AST_ZERO_OPERAND: assert (!(a_i == '0 || b_i == '0) || (p_o == '0 && q_o == '0)) else $error("zero operand"); // R5
      AST_NO_SPILL: assert (!row_spill) else $error("row spill"); // R6
      AST_COL0_BIT: assert (p_o[0] == (a_i[0] & b_i[0])) else $error("col0"); // R7
    end
  end
endmodule

bind csmul6x6 csmul6x6_chk #(
  .A_W(A_W),
  .B_W(B_W)
) u_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .p_o      (p_o),
  .q_o      (q_o),
  .row_spill(row_spill)
);

// File: tb/sim_csmul6x6.sv
`timescale 1ns/1ps
module sim_csmul6x6;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  a_r;
  logic [5:0]  b_r;
  logic [10:0] p_w;
  logic [5:0]  q_w;

  typedef struct packed {
    logic [5:0]  a;
    logic [5:0]  b;
    logic [11:0] prod;
    logic [10:0] p_exp;
    logic [5:0]  q_exp;
  } item_t;

  item_t sb_q[$];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  always #4 clk = ~clk;

  csmul6x6 u0 (
    .a_i(a_r),
    .b_i(b_r),
    .p_o(p_w),
    .q_o(q_w)
  );

  task automatic check(input string req, input int got, input int exp, input item_t it);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, it.a, it.b, got, exp);
    end
  endtask

  // driver: apply operands after a rising edge, queue the expectation
  task automatic drive(input int av, input int bv);
    item_t it;
    @(posedge clk);
    a_r <= 6'(av);
    b_r <= 6'(bv);
    it.a     = 6'(av);
    it.b     = 6'(bv);
    it.prod  = 12'(av * bv);
    it.p_exp = 11'(av * (bv % 32));
    it.q_exp = (bv >= 32) ? 6'(av) : 6'd0;
    sb_q.push_back(it);
  endtask

  // monitor: zero-latency results compared half a period after the drive
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check("R1", int'(p_w) + (int'(q_w) << 5), int'(it.prod), it);
      if (!it.b[5]) check("R2", int'(q_w), 0, it);
      else          check("R3", int'(q_w), int'(it.a), it);
      check("R4", int'(p_w), int'(it.p_exp), it);
      if (it.a == 6'd0 || it.b == 6'd0) check("R5", int'({p_w, q_w}), 0, it);
      check("R6", int'(p_w <= 11'd1953), 1, it);
      check("R7", int'(p_w[0]), int'(it.a[0] & it.b[0]), it);
    end
  end

  initial begin
    item_t z;
    z = '0;
    rst_n = 1'b0;
    a_r   = '0;
    b_r   = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R5 reset", int'({p_w, q_w}), 0, z);
    rst_n = 1'b1;
    // directed corners
    drive(0, 0);
    drive(63, 0);
    drive(0, 63);
    drive(63, 63);   // R6: p=1953, q=63, bit 11 only in the sum
    drive(63, 31);
    drive(5, 32);    // R3: only b[5] set
    drive(1, 1);
    drive(21, 42);
    drive(42, 21);
    // exhaustive sweep
    for (int av = 0; av < 64; av++) begin
      for (int bv = 0; bv < 64; bv++) drive(av, bv);
    end
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule